// File: doc/BRIEF.md
# Nine-Channel Pulse-Width Modulator with Stepped Period Selection

This block drives nine output pins. Each pin is either a PWM output or a static general-purpose output. All PWM channels share one timebase. A 5-bit period code selects the timebase, and each channel compares the shared step position against its own 9-bit pulse-width word. The block runs from the oscillator clock, and its outputs go straight to the pins.

Period codes with the top bit clear give 256 steps per period. Each step lasts (16 − code) clock cycles, so the period runs from 4096 cycles down to 256 cycles. Period codes with the top bit set give a 128-cycle period of 128 one-cycle steps. A pulse-width word that reaches the step count holds the pin high for the whole period. A new pulse-width word is used only from the next period boundary. When the period code changes, the timebase restarts at step 0.

All inputs are level-held configuration written by an external register file. There is no data stream at the edge of this block, so no port uses a valid/ready handshake. Every input is a plain level, and every output is a registered pin.

Top module: `pwm9_top`

## Requirements
- R1: For a period code c with bit 4 clear, the period is (4096 − 256·c) clock cycles. It is made of 256 steps of (16 − c) cycles each.
- R2: For any period code with bit 4 set, the period is 128 clock cycles, made of 128 one-cycle steps.
- R3: With bit 4 of the code clear, a PWM pin is high for min(duty, 256)·(16 − c) cycles per period. A duty of 0 keeps the pin low.
- R4: With bit 4 of the code set, a PWM pin is high for min(duty, 128) cycles per period. Any duty of 128 or more keeps the pin high.
- R5: When the channel's `gpo_sel` bit is 1, its pin equals its `gpo_data` bit one clock later. When the bit is 0, the channel runs as PWM.
- R6: A pulse-width word changed during a period has no effect until the next period starts. The remaining part of the current period uses the old word.
- R7: During reset, and for the first period after reset, all pins are low. Reset selects code 0 and a duty of 0 on every channel.
- R8: While `power_save` is 1, every PWM-mode pin is driven low. General-purpose pins keep following their data bits.
- R9: A change of the period code restarts the timebase at step 0 on the next clock edge. The pin reflects step 0 one clock after that edge.
- R10: Within a period, the high part comes first. The pin is high while the step index is below the duty word and low from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_code | input | 5 | Shared period selection code |
| duty_words | input | 81 | Nine 9-bit pulse-width words; channel k occupies bits [9k+8:9k] |
| gpo_sel | input | 9 | Per-channel mode: 0 = PWM, 1 = general-purpose |
| gpo_data | input | 9 | Per-channel level driven in general-purpose mode |
| power_save | input | 1 | Forces PWM-mode pins low |
| pwm_pin | output | 9 | Registered output pins |

## Verification
The bound assertions check four behaviours on every cycle:
- In general-purpose mode, the pin follows its data bit one cycle later.
- Under power saving, PWM pins stay low.
- Each channel's active pulse-width word stays fixed except at a period load, and a code change sends the step index back to zero.
- In the 128-step mode, the step index never reaches 128.

Whole-period behaviour needs the bench's scenarios: the high-time count for each code and duty value, saturation, the deferred update across two periods, and the position of the high part after a restart. Those scenarios count high cycles over exact windows that start at a forced restart.

// File: rtl/pwm9_pkg.sv
package pwm9_pkg;
  localparam int unsigned CH_N   = 9;
  localparam int unsigned DUTY_W = 9;
  localparam int unsigned CODE_W = 5;

  typedef enum logic {
    CH_PWM = 1'b0,
    CH_GPO = 1'b1
  } ch_mode_e;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CODE_W = pwm9_pkg::CODE_W,
  parameter int DUTY_W = pwm9_pkg::DUTY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  output logic [DUTY_W-2:0] step,
  output logic              load,
  output logic [CODE_W-1:0] code_reg
);
  localparam int STEP_W = DUTY_W - 1;
  localparam int FINE   = 1 << STEP_W;
  localparam int COARSE = FINE >> 1;
  localparam int PRE_W  = CODE_W - 1;

  logic [PRE_W-1:0]  pre_q, pre_last;
  logic [STEP_W-1:0] step_q, step_last;
  logic              coarse, pre_end, per_end, chg;

  // step length minus one is (2^PRE_W - 1 - code) = bitwise inverse of the low code bits
  assign coarse    = code_reg[CODE_W-1];
  assign pre_last  = coarse ? '0 : ~code_reg[PRE_W-1:0];
  assign step_last = coarse ? STEP_W'(COARSE - 1) : STEP_W'(FINE - 1);
  assign pre_end   = (pre_q == pre_last);
  assign per_end   = pre_end && (step_q == step_last);
  assign chg       = (code != code_reg);
  assign load      = chg || per_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_reg <= '0;
      pre_q    <= '0;
      step_q   <= '0;
    end else if (chg) begin
      code_reg <= code;
      pre_q    <= '0;
      step_q   <= '0;
    end else if (pre_end) begin
      pre_q  <= '0;
      step_q <= per_end ? '0 : step_q + STEP_W'(1);
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  assign step = step_q;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int DUTY_W = pwm9_pkg::DUTY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DUTY_W-2:0] step,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic              mode,
  input  logic              gpo,
  input  logic              psave,
  output logic              pin,
  output logic [DUTY_W-1:0] duty_now
);
  import pwm9_pkg::*;

  logic [DUTY_W-1:0] duty_q;
  logic              pwm_hi;

  // saturation falls out naturally: step never reaches the step count
  assign pwm_hi = ({1'b0, step} < duty_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      pin    <= 1'b0;
    end else begin
      if (load) duty_q <= duty_in;
      if (ch_mode_e'(mode) == CH_GPO) pin <= gpo;
      else                            pin <= !psave && pwm_hi;
    end
  end

  assign duty_now = duty_q;
endmodule

// File: rtl/pwm9_top.sv
module pwm9_top #(
  parameter int CH_N   = pwm9_pkg::CH_N,
  parameter int DUTY_W = pwm9_pkg::DUTY_W,
  parameter int CODE_W = pwm9_pkg::CODE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CODE_W-1:0]      period_code,
  input  logic [CH_N*DUTY_W-1:0] duty_words,
  input  logic [CH_N-1:0]        gpo_sel,
  input  logic [CH_N-1:0]        gpo_data,
  input  logic                   power_save,
  output logic [CH_N-1:0]        pwm_pin
);
  logic [DUTY_W-2:0]        step;
  logic                     load;
  logic [CODE_W-1:0]        code_reg;
  logic [CH_N*DUTY_W-1:0]   duty_live;

  pwm_timebase #(.CODE_W(CODE_W), .DUTY_W(DUTY_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .code(period_code),
    .step(step), .load(load), .code_reg(code_reg)
  );

  for (genvar k = 0; k < CH_N; k++) begin : g_ch
    pwm_chan #(.DUTY_W(DUTY_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .duty_in(duty_words[k*DUTY_W +: DUTY_W]),
      .mode(gpo_sel[k]), .gpo(gpo_data[k]), .psave(power_save),
      .pin(pwm_pin[k]), .duty_now(duty_live[k*DUTY_W +: DUTY_W])
    );
  end
endmodule

// File: rtl/pwm9_chk.sv
module pwm9_chk #(
  parameter int CH_N   = 9,
  parameter int DUTY_W = 9,
  parameter int CODE_W = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [CODE_W-1:0]      code,
  input logic [CODE_W-1:0]      code_reg,
  input logic [DUTY_W-2:0]      step,
  input logic                   load,
  input logic [CH_N*DUTY_W-1:0] duty_live,
  input logic [CH_N-1:0]        mode,
  input logic [CH_N-1:0]        gpo,
  input logic                   psave,
  input logic [CH_N-1:0]        pin
);
  localparam int COARSE = (1 << (DUTY_W - 1)) >> 1;

  p_gpo_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pin ^ $past(gpo)) & $past(mode)) == '0));

  p_psave_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    psave |=> ((pin & ~$past(mode)) == '0));

  p_duty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(duty_live));

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (code != code_reg) |=> (step == '0));

  p_coarse_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    code_reg[CODE_W-1] |-> (int'(step) < COARSE));
endmodule

bind pwm9_top pwm9_chk #(.CH_N(CH_N), .DUTY_W(DUTY_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .code(period_code), .code_reg(code_reg),
  .step(step), .load(load), .duty_live(duty_live), .mode(gpo_sel),
  .gpo(gpo_data), .psave(power_save), .pin(pwm_pin)
);

// File: tb/test_pwm9_top.sv
module test_pwm9_top;
  localparam int NCH = 9;
  localparam int DW  = 9;
  localparam int CW  = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [CW-1:0]     period_code;
  logic [NCH*DW-1:0] duty_words;
  logic [NCH-1:0]    gpo_sel, gpo_data, pwm_pin;
  logic              power_save;

  always #2 clk = ~clk;

  pwm9_top i_pwm9_top (
    .clk(clk), .rst_n(rst_n), .period_code(period_code), .duty_words(duty_words),
    .gpo_sel(gpo_sel), .gpo_data(gpo_data), .power_save(power_save), .pwm_pin(pwm_pin)
  );

  int total = 0, bad = 0, pushed = 0, done_items = 0;
  int    q_len[$];
  int    q_cont[$];
  int    q_hi[$];
  string q_req[$];

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int per_len(input int c);
    return (c >= 16) ? 128 : 4096 - 256 * c;
  endfunction

  function automatic int hi_of(input int c, input int d, input logic m, input logic g, input logic ps);
    if (m) return g ? per_len(c) : 0;
    if (ps) return 0;
    if (c >= 16) return (d >= 128) ? 128 : d;
    return ((d >= 256) ? 256 : d) * (16 - c);
  endfunction

  task automatic apply_duties(input int dv[NCH]);
    for (int ch = 0; ch < NCH; ch++) duty_words[ch*DW +: DW] = 9'(dv[ch]);
  endtask

  task automatic push(input int cont, input string req, input int c, input int dv[NCH]);
    q_len.push_back(per_len(c));
    q_cont.push_back(cont);
    q_req.push_back(req);
    for (int ch = 0; ch < NCH; ch++)
      q_hi.push_back(hi_of(c, dv[ch], gpo_sel[ch], gpo_data[ch], power_save));
    pushed++;
  endtask

  // forces a restart: the final code change lands on the next rising edge
  task automatic restart(input int c);
    @(negedge clk) period_code = 5'(c ^ 1);
    @(negedge clk) period_code = 5'(c);
  endtask

  task automatic scenario(input string req, input int c, input int dv[NCH]);
    @(negedge clk) apply_duties(dv);
    restart(c);
    push(0, req, c, dv);
    wait (done_items == pushed);
  endtask

  // monitor: counts high cycles per channel over each expected window
  initial begin
    forever begin
      int len, cont;
      string req;
      int cnt[NCH];
      wait (q_len.size() > 0);
      len  = q_len.pop_front();
      cont = q_cont.pop_front();
      req  = q_req.pop_front();
      for (int ch = 0; ch < NCH; ch++) cnt[ch] = 0;
      if (cont == 0) @(posedge clk);
      for (int k = 0; k < len; k++) begin
        @(posedge clk); #1;
        for (int ch = 0; ch < NCH; ch++) cnt[ch] += int'(pwm_pin[ch]);
      end
      for (int ch = 0; ch < NCH; ch++) check(req, cnt[ch], q_hi.pop_front());
      done_items++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int dv[NCH];
    int dv2[NCH];
    rst_n = 1'b0; period_code = '0; gpo_sel = '0; gpo_data = '0; power_save = 1'b0;
    for (int ch = 0; ch < NCH; ch++) duty_words[ch*DW +: DW] = 9'd5;
    repeat (3) @(posedge clk); #1;
    check("R7 pins in reset", int'(pwm_pin), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    check("R7 first period after reset low", int'(pwm_pin), 0);

    // R1 R3 fine resolution, 256-cycle period, with one general-purpose channel (R5)
    gpo_sel[8] = 1'b1; gpo_data[8] = 1'b1;
    dv = '{0, 1, 2, 100, 255, 256, 300, 511, 7};
    scenario("R3 code15", 15, dv);
    gpo_sel = '0; gpo_data = '0;
    dv = '{0, 5, 17, 128, 200, 255, 256, 400, 1};
    scenario("R1 code13", 13, dv);
    dv = '{1, 2, 255, 256, 300, 0, 64, 511, 3};
    scenario("R1 code0", 0, dv);

    // R2 R4 coarse resolution
    dv = '{0, 1, 64, 127, 128, 200, 511, 255, 9};
    scenario("R4 code16", 16, dv);
    dv = '{3, 0, 127, 128, 129, 40, 90, 1, 511};
    scenario("R2 code31", 31, dv);

    // R6 deferred update across two contiguous periods
    dv  = '{10, 10, 10, 10, 10, 0, 200, 127, 60};
    dv2 = '{50, 0, 128, 1, 10, 90, 20, 3, 60};
    @(negedge clk) apply_duties(dv);
    restart(16);
    push(0, "R6 old period", 16, dv);
    push(1, "R6 new period", 16, dv2);
    repeat (10) @(negedge clk);
    apply_duties(dv2);
    wait (done_items == pushed);

    // R8 power save: PWM pins low, general-purpose pins keep following
    power_save = 1'b1;
    gpo_sel[8] = 1'b1; gpo_data[8] = 1'b1; gpo_sel[7] = 1'b1; gpo_data[7] = 1'b0;
    dv = '{300, 300, 300, 300, 300, 300, 300, 300, 300};
    scenario("R8 psave", 15, dv);
    power_save = 1'b0; gpo_sel = '0; gpo_data = '0;

    // R9 R10 restart mid-period and high-first shape
    dv = '{20, 20, 20, 20, 20, 20, 20, 20, 20};
    @(negedge clk) apply_duties(dv);
    restart(16);
    @(posedge clk);
    repeat (50) @(posedge clk); #1;
    check("R10 low after duty steps", int'(pwm_pin[0]), 0);
    @(negedge clk) period_code = 5'd17;
    @(posedge clk);
    @(posedge clk); #1;
    check("R9 step0 after code change", int'(pwm_pin[0]), 1);
    repeat (18) @(posedge clk);
    @(posedge clk); #1;
    check("R10 last high step", int'(pwm_pin[0]), 1);
    @(posedge clk); #1;
    check("R10 first low step", int'(pwm_pin[0]), 0);

    // R5 general-purpose follow, also under power save (R8)
    @(negedge clk) gpo_sel = '1; gpo_data = 9'h0A5;
    @(posedge clk); #1;
    check("R5 gpo pattern a", int'(pwm_pin), 'h0A5);
    @(negedge clk) gpo_data = 9'h15A; power_save = 1'b1;
    @(posedge clk); #1;
    check("R8 gpo active in psave", int'(pwm_pin), 'h15A);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule